// File: doc/BRIEF.md
# Configuration Clock Burst Counter

This block sends a programmed number of clock pulses to a device that is being configured. Each pulse is a clock-enable pulse that qualifies the system clock. Software writes a count N into the count register. The block then drives N pulses on its enable output, each one cycle high and one cycle low. When the last pulse ends, the block sets a sticky done flag in the status register.

The done flag is write-one-to-clear. Software is expected to clear any stale flag before it loads a new count. A typical use is a short trailing burst, such as four pulses, after the configuration data has ended, so that the device can complete its startup sequence. A count write that arrives while a burst is running is dropped. While a burst runs, reading the count register shows how many pulses remain.

Top module: `clk_burst_ctrl`

## Requirements
- R1: After reset, the enable output is 0, the count register reads 0 and the status register reads 0.
- R2: A write of N > 0 to the count register (address 0, count in bits CNT_W-1:0) while idle produces exactly N pulses on the enable output. The first high cycle is the cycle right after the write. Each pulse is one cycle high followed by one cycle low, so the burst takes 2N cycles.
- R3: Status bit 0 (the done flag, address 1) stays 0 while the burst runs. It reads 1 starting 2N cycles after the write cycle.
- R4: The count register reads the number of pulses still to complete. It reads N right after the write, drops by 1 after each completed high/low pair, and reads 0 once the burst is over.
- R5: A write of 0 to the count register while idle sets the done flag on the next cycle and produces no pulse.
- R6: Writing the status register with bit 0 = 1 clears the done flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R7: A write to the count register during a burst is ignored. The remaining count and the total number of pulses are unaffected.
- R8: The done flag is sticky. It is not cleared by reads, and it is not cleared by starting a new burst.
- R9: Addresses other than 0 and 1 read as 0, and writes to them have no effect. Status bits above bit 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register address: 0 count, 1 status |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, from registered state |
| pulse_en | output | 1 | Clock-enable pulse train for the configuration clock |

## Verification
The bench goes after the following boundary cases and the failure each one would expose:
- **Single-pulse burst.** An off-by-one in the terminal test would give zero or two pulses.
- **Zero count.** A broken design would either hang busy or wrap to a huge burst; a correct one sets the done flag next cycle with no pulse.
- **Count write landing mid-burst.** If the write is not ignored, the design reloads and the pulse total and remaining count change.
- **Write-one-to-clear semantics, both polarities.** A design that treats the status register as plain storage would lose the flag on a zero write.
- **Done flag while a new burst starts.** A design that auto-clears on start would drop the flag.

A scoreboard groups the observed pulses into bursts and compares each total against the count that was launched. A stretched pulse or a wrong gap shows up as a split or merged group.

// File: rtl/clk_burst_pkg.sv
package clk_burst_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_COUNT  = 2'd0,
        REG_STATUS = 2'd1
    } reg_sel_e;

    // Engine state: busy marks an active burst, low_half marks the low cycle of a pulse
    typedef struct packed {
        logic busy;
        logic low_half;
    } eng_state_t;

    function automatic logic is_addr(input logic [ADDR_W-1:0] a, input reg_sel_e sel);
        return a == sel;
    endfunction

endpackage

// File: rtl/burst_decode.sv
module burst_decode
    import clk_burst_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic [CNT_W-1:0]  remaining,
    input  logic              done_flag,
    output logic              load_req,
    output logic              clr_req,
    output logic [CNT_W-1:0]  rdata
);

    assign load_req = reg_wr && is_addr(reg_addr, REG_COUNT);
    assign clr_req  = reg_wr && is_addr(reg_addr, REG_STATUS) && reg_wdata[0];

    always_comb begin
        rdata = '0;
        if (is_addr(reg_addr, REG_COUNT)) begin
            rdata = remaining;
        end else if (is_addr(reg_addr, REG_STATUS)) begin
            rdata[0] = done_flag;
        end
    end

endmodule

// File: rtl/burst_engine.sv
module burst_engine
    import clk_burst_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic [CNT_W-1:0] remaining,
    output logic             pulse_en,
    output logic             finish
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    eng_state_t       st_q;
    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            rem_q <= '0;
        end else if (!st_q.busy) begin
            if (load_req && (load_val != '0)) begin
                st_q.busy     <= 1'b1;
                st_q.low_half <= 1'b0;
                rem_q         <= load_val;
            end
        end else if (!st_q.low_half) begin
            st_q.low_half <= 1'b1;
        end else begin
            st_q.low_half <= 1'b0;
            rem_q         <= rem_q - ONE;
            if (rem_q == ONE) begin
                st_q.busy <= 1'b0;
            end
        end
    end

    assign busy      = st_q.busy;
    assign remaining = rem_q;
    assign pulse_en  = st_q.busy && !st_q.low_half;
    assign finish    = (!st_q.busy && load_req && (load_val == '0))
                     || (st_q.busy && st_q.low_half && (rem_q == ONE));

endmodule

// File: rtl/burst_status.sv
module burst_status (
    input  logic clk,
    input  logic rst,
    input  logic finish,
    input  logic clr_req,
    output logic done_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_flag <= 1'b0;
        end else if (finish) begin
            done_flag <= 1'b1;
        end else if (clr_req) begin
            done_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/clk_burst_ctrl.sv
module clk_burst_ctrl
    import clk_burst_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              pulse_en
);

    logic             load_req;
    logic             clr_req;
    logic             busy;
    logic             finish;
    logic             done_flag;
    logic [CNT_W-1:0] remaining;

    burst_decode #(.CNT_W(CNT_W)) u_decode (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .remaining (remaining),
        .done_flag (done_flag),
        .load_req  (load_req),
        .clr_req   (clr_req),
        .rdata     (reg_rdata)
    );

    burst_engine #(.CNT_W(CNT_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .load_req  (load_req),
        .load_val  (reg_wdata),
        .busy      (busy),
        .remaining (remaining),
        .pulse_en  (pulse_en),
        .finish    (finish)
    );

    burst_status u_status (
        .clk       (clk),
        .rst       (rst),
        .finish    (finish),
        .clr_req   (clr_req),
        .done_flag (done_flag)
    );

endmodule

// File: rtl/clk_burst_ctrl_chk.sv
module clk_burst_ctrl_chk
    import clk_burst_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [CNT_W-1:0]  reg_wdata,
    input logic              pulse_en,
    input logic              busy,
    input logic [CNT_W-1:0]  remaining,
    input logic              done_flag,
    input logic              finish
);

    logic wr_cnt;
    logic wr_sts;
    assign wr_cnt = reg_wr && (reg_addr == REG_COUNT);
    assign wr_sts = reg_wr && (reg_addr == REG_STATUS);

    assert_pulse_one_high_R2: assert property (@(posedge clk) disable iff (rst)
        pulse_en |=> !pulse_en);

    assert_pulse_in_burst_R2: assert property (@(posedge clk) disable iff (rst)
        pulse_en |-> busy);

    assert_done_from_finish_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> $past(finish));

    assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
        busy |=> (remaining <= $past(remaining)));

    assert_zero_count_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt && !busy && (reg_wdata == '0)) |=> (done_flag && !pulse_en));

    assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && reg_wdata[0] && !finish) |=> !done_flag);

    assert_w0_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && !reg_wdata[0] && done_flag) |=> done_flag);

    assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_cnt) |=> ((remaining == $past(remaining))
                              || (remaining == ($past(remaining) - CNT_W'(1)))));

    assert_sticky_on_start_R8: assert property (@(posedge clk) disable iff (rst)
        (done_flag && !wr_sts) |=> done_flag);

endmodule

bind clk_burst_ctrl clk_burst_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pulse_en  (pulse_en),
    .busy      (busy),
    .remaining (remaining),
    .done_flag (done_flag),
    .finish    (finish)
);

// File: tb/tb_clk_burst_ctrl.sv
module tb_clk_burst_ctrl;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic [CNT_W-1:0] reg_rdata;
    logic             pulse_en;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    int grp_cnt  = 0;
    int low_run  = 0;

    clk_burst_ctrl #(.CNT_W(CNT_W)) dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pulse_en  (pulse_en)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input int d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = CNT_W'(d);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic expect_rd(input logic [1:0] a, input int exp, input string req);
        int v;
        bus_rd(a, v);
        chk(v == exp, req, v, exp);
    endtask

    // Driver: launch an N-pulse burst, queue it for the monitor, check the registers
    task automatic run_burst(input int n);
        exp_q.push_back(n);
        bus_wr(2'd0, n);
        chk(pulse_en == 1'b1, "R2 first pulse", int'(pulse_en), 1);
        expect_rd(2'd0, n, "R4 count after load");
        if (n >= 2) begin
            repeat (2) @(negedge clk);
            expect_rd(2'd0, n - 1, "R4 count after one pulse");
            repeat (2 * n - 3) @(negedge clk);
        end else begin
            @(negedge clk);
        end
        expect_rd(2'd1, 0, "R3 done not yet set");
        @(negedge clk);
        expect_rd(2'd1, 1, "R3 done after 2N cycles");
        expect_rd(2'd0, 0, "R4 count at end");
    endtask

    // Monitor: group pulses into bursts, compare totals with the queue
    always @(negedge clk) begin
        if (!rst) begin
            if (pulse_en) begin
                grp_cnt++;
                low_run = 0;
            end else if (grp_cnt > 0) begin
                low_run++;
                if (low_run == 2) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 unexpected burst", grp_cnt, 0);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        chk(grp_cnt == e, "R2 pulse total", grp_cnt, e);
                    end
                    grp_cnt = 0;
                    low_run = 0;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pulse_en == 1'b0, "R1 enable idle", int'(pulse_en), 0);
        expect_rd(2'd0, 0, "R1 count reset");
        expect_rd(2'd1, 0, "R1 status reset");

        run_burst(3);
        bus_wr(2'd1, 1);
        expect_rd(2'd1, 0, "R6 write one clears");

        run_burst(1);
        bus_wr(2'd1, 0);
        expect_rd(2'd1, 1, "R6 write zero keeps");
        bus_wr(2'd1, 1);

        run_burst(4);

        // R8: done stays set across reads and a new burst
        expect_rd(2'd1, 1, "R8 sticky after read");
        exp_q.push_back(2);
        bus_wr(2'd0, 2);
        expect_rd(2'd1, 1, "R8 sticky at new start");
        repeat (6) @(negedge clk);
        bus_wr(2'd1, 1);

        // R5: zero count
        bus_wr(2'd0, 0);
        expect_rd(2'd1, 1, "R5 done after zero load");
        chk(pulse_en == 1'b0, "R5 no pulse", int'(pulse_en), 0);
        @(negedge clk);
        chk(pulse_en == 1'b0, "R5 no pulse later", int'(pulse_en), 0);
        bus_wr(2'd1, 1);

        // R7: count write mid-burst ignored
        exp_q.push_back(5);
        bus_wr(2'd0, 5);
        repeat (3) @(negedge clk);
        bus_wr(2'd0, 9);
        expect_rd(2'd0, 3, "R7 remaining after ignored write");
        repeat (8) @(negedge clk);
        expect_rd(2'd1, 1, "R7 burst completes");
        bus_wr(2'd1, 1);

        // R9: unmapped addresses
        bus_wr(2'd3, 7);
        bus_wr(2'd2, 1);
        chk(pulse_en == 1'b0, "R9 no pulse from unmapped write", int'(pulse_en), 0);
        expect_rd(2'd2, 0, "R9 unmapped read");
        expect_rd(2'd3, 0, "R9 unmapped read");
        expect_rd(2'd1, 0, "R9 status unchanged");
        run_burst(2);
        bus_wr(2'd1, 16'hFFFE);
        expect_rd(2'd1, 1, "R9 upper status bits zero and R6 keep");

        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all bursts seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule